// File: doc/BRIEF.md
# Overlapping-Trigger Readout Length Calculator

This block sits in a front-end board and runs on the same clock as the latency pipeline. Every trigger pulse yields one descriptor. The descriptor tells the downstream reader how many samples to take out of the latency pipeline for that trigger. The samples then go to the readout module.

Two triggers can arrive close enough that their readout windows overlap. In that case the later trigger asks only for the samples past the end of the earlier window, so no sample is ever sent twice. The readout module rebuilds the full event from the descriptors.

A trigger can carry a go-back flag. The flag stretches its length by a programmed extension, which reaches further into the past. In fixed mode one programmed window serves every trigger. In variable mode each trigger supplies its own window. The block measures trigger spacing with a saturating counter, computes the length in a two-stage register pipeline, and drives the write side of an external descriptor FIFO. When that FIFO reports full, the block drops the descriptor and raises a sticky error.

Top module: `olap_readout_len`

## Requirements
- R1: The spacing Dn of a trigger is the number of clock cycles since the previous trigger. It saturates at 2^CNT_W-1 and never wraps. The first trigger after reset sees the saturated value.
- R2: In fixed mode (`var_mode_i`=0) with programmed window W, the length is W and the fresh bit is 1 when Dn >= W. Otherwise the length is Dn and the fresh bit is 0.
- R3: When `back_i` is 1 with a trigger, the programmed extension `cfg_ext_i` is added to that trigger's length (after any clamp), and the descriptor's back bit is 1.
- R4: In variable mode (`var_mode_i`=1) each trigger n takes its window Wn from `evt_win_i`. The length is Wn, with fresh=1, when Dn >= W(n-1). Otherwise the length is Dn + Wn - W(n-1), with fresh=0. W(n-1) is the window in force for the previous trigger, whichever mode that trigger was in.
- R5: When the variable-mode result Dn + Wn - W(n-1) is negative, the base length becomes 0 and the descriptor's clamp bit is 1. In every other case the clamp bit is 0.
- R6: The descriptor holds these fields, from bit 0 upward: length in [WIN_W+1:0], the trigger's window in the next WIN_W bits, then the clamp bit, then the back bit, and the fresh bit at the MSB. With the defaults these are len [9:0], win [17:10], clamp 18, back 19 and fresh 20.
- R7: A trigger sampled at a rising edge produces `push_o`=1 two cycles later. Triggers may come on consecutive cycles with no dead time, and each one yields its own descriptor in order.
- R8: If `fifo_full_i` is 1 in the cycle a descriptor is due, `push_o` stays 0 and that descriptor is lost. `ovf_err_o` then goes to 1 and stays there until reset. A dropped trigger still counts as the previous trigger for spacing and window.
- R9: During reset and right after it, `push_o` and `ovf_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger pulse, one per cycle at most |
| back_i | input | 1 | Go-back request for the trigger in the same cycle |
| evt_win_i | input | WIN_W | Per-trigger window (variable mode) |
| var_mode_i | input | 1 | 0 fixed window, 1 per-trigger window |
| cfg_win_i | input | WIN_W | Programmed window (fixed mode) |
| cfg_ext_i | input | WIN_W | Programmed back-in-time extension |
| fifo_full_i | input | 1 | Descriptor FIFO full |
| push_o | output | 1 | Descriptor FIFO write enable |
| push_desc_o | output | 2*WIN_W+5 | Descriptor written to the FIFO |
| ovf_err_o | output | 1 | Sticky descriptor-drop error |

## Verification
Within one clock cycle, the spacing counter can be restarting for a new trigger while the descriptor of an earlier trigger is being pushed. The bench provokes this with bursts at spacings of one and two cycles. For each descriptor it computes the expected length from its own record of trigger times, and requires every length to equal that spacing, in order and with none missing. A second coincidence is a trigger's descriptor falling due while the FIFO reports full. Here the bench requires that no write happens, that the error bit rises and stays set, and that the next trigger is still measured from the dropped one.

// File: rtl/olr_pkg.sv
`timescale 1ns/1ps
package olr_pkg;
   typedef enum logic {
      WMODE_FIXED = 1'b0,
      WMODE_VAR   = 1'b1
   } wmode_e;

   function automatic int unsigned olr_len_width(input int unsigned win_w);
      return win_w + 2;
   endfunction

   function automatic int unsigned olr_desc_width(input int unsigned win_w);
      return 3 + win_w + olr_len_width(win_w);
   endfunction
endpackage

// File: rtl/olr_gap_counter.sv
`timescale 1ns/1ps
module olr_gap_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   output logic [CNT_W-1:0] gap_o
);
   localparam logic [CNT_W-1:0] GAP_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   // Reset to the saturated value so the first trigger sees a huge spacing.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= GAP_MAX;
      else if (trig_i)         cnt_q <= CNT_W'(1);
      else if (cnt_q != GAP_MAX) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign gap_o = cnt_q;

   p_gap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> (gap_o == CNT_W'(1)));

   p_gap_saturate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_i && gap_o == GAP_MAX) |=> (gap_o == GAP_MAX));
endmodule

// File: rtl/olr_len_calc.sv
`timescale 1ns/1ps
module olr_len_calc
   import olr_pkg::*;
#(
   parameter int unsigned WIN_W  = 8,
   parameter int unsigned CNT_W  = 12,
   parameter bit          EXT_EN = 1'b1,
   localparam int unsigned LEN_W  = olr_len_width(WIN_W),
   localparam int unsigned DESC_W = olr_desc_width(WIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              back_i,
   input  logic [WIN_W-1:0]  evt_win_i,
   input  logic              var_mode_i,
   input  logic [WIN_W-1:0]  cfg_win_i,
   input  logic [WIN_W-1:0]  cfg_ext_i,
   input  logic [CNT_W-1:0]  gap_i,
   output logic              vld_o,
   output logic [DESC_W-1:0] desc_o
);
   localparam int unsigned SW = LEN_W + 1;

   wmode_e           mode;
   logic [WIN_W-1:0] cur_win;
   logic [WIN_W-1:0] prev_win_q;

   assign mode    = wmode_e'(var_mode_i);
   assign cur_win = (mode == WMODE_VAR) ? evt_win_i : cfg_win_i;

   // ---------------- stage 1: capture trigger context ----------------
   logic             s1_vld, s1_back;
   logic [CNT_W-1:0] s1_gap;
   logic [WIN_W-1:0] s1_win, s1_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld     <= 1'b0;
         s1_back    <= 1'b0;
         s1_gap     <= '0;
         s1_win     <= '0;
         s1_ref     <= '0;
         prev_win_q <= '0;
      end else begin
         s1_vld <= trig_i;
         if (trig_i) begin
            s1_back    <= back_i;
            s1_gap     <= gap_i;
            s1_win     <= cur_win;
            s1_ref     <= (mode == WMODE_VAR) ? prev_win_q : cur_win;
            prev_win_q <= cur_win;
         end
      end
   end

   // ---------------- stage 2: length arithmetic ----------------
   logic                 fresh, clamp;
   logic signed [SW-1:0] diff;
   logic [LEN_W-1:0]     base, ext_add, len;

   assign fresh = (s1_gap >= CNT_W'(s1_ref));
   assign diff  = $signed({3'b000, s1_gap[WIN_W-1:0]})
                + $signed({3'b000, s1_win})
                - $signed({3'b000, s1_ref});
   assign clamp = !fresh && diff[SW-1];

   always_comb begin
      if (fresh)      base = LEN_W'(s1_win);
      else if (clamp) base = '0;
      else            base = diff[LEN_W-1:0];
   end

   generate
      if (EXT_EN) begin : g_ext
         logic [WIN_W-1:0] s1_ext;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      s1_ext <= '0;
            else if (trig_i) s1_ext <= cfg_ext_i;
         end
         assign ext_add = s1_back ? LEN_W'(s1_ext) : '0;
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ^cfg_ext_i;
         assign ext_add    = '0;
      end
   endgenerate

   assign len = base + ext_add;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         desc_o <= '0;
      end else begin
         vld_o <= s1_vld;
         if (s1_vld) desc_o <= {fresh, s1_back, clamp, s1_win, len};
      end
   end

   // A clamped result can only come from an overlapping (non-fresh) trigger.
   p_clamp_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && desc_o[DESC_W-3]) |-> !desc_o[DESC_W-1]);

   // Without extension a trigger never asks for more than its own window.
   p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !desc_o[DESC_W-2]) |->
         (desc_o[LEN_W-1:0] <= LEN_W'(desc_o[LEN_W+WIN_W-1:LEN_W])));
endmodule

// File: rtl/olr_push_stage.sv
`timescale 1ns/1ps
module olr_push_stage #(
   parameter int unsigned DESC_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [DESC_W-1:0] desc_i,
   input  logic              fifo_full_i,
   output logic              push_o,
   output logic [DESC_W-1:0] push_desc_o,
   output logic              ovf_err_o
);
   assign push_o      = vld_i && !fifo_full_i;
   assign push_desc_o = desc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ovf_err_o <= 1'b0;
      else if (vld_i && fifo_full_i) ovf_err_o <= 1'b1;
   end

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err_o |=> ovf_err_o);

   p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_err_o) |-> $past(fifo_full_i));
endmodule

// File: rtl/olap_readout_len.sv
`timescale 1ns/1ps
module olap_readout_len
   import olr_pkg::*;
#(
   parameter int unsigned WIN_W  = 8,
   parameter int unsigned CNT_W  = 12,
   parameter bit          EXT_EN = 1'b1,
   localparam int unsigned DESC_W = olr_desc_width(WIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              back_i,
   input  logic [WIN_W-1:0]  evt_win_i,
   input  logic              var_mode_i,
   input  logic [WIN_W-1:0]  cfg_win_i,
   input  logic [WIN_W-1:0]  cfg_ext_i,
   input  logic              fifo_full_i,
   output logic              push_o,
   output logic [DESC_W-1:0] push_desc_o,
   output logic              ovf_err_o
);
   generate
      if (WIN_W < 2)      begin : g_bad_win $error("WIN_W must be at least 2"); end
      if (CNT_W <= WIN_W) begin : g_bad_cnt $error("CNT_W must exceed WIN_W so saturation covers any window"); end
   endgenerate

   logic [CNT_W-1:0]  gap;
   logic              calc_vld;
   logic [DESC_W-1:0] calc_desc;

   olr_gap_counter #(.CNT_W(CNT_W)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i),
      .gap_o  (gap)
   );

   olr_len_calc #(.WIN_W(WIN_W), .CNT_W(CNT_W), .EXT_EN(EXT_EN)) u_calc (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig_i),
      .back_i     (back_i),
      .evt_win_i  (evt_win_i),
      .var_mode_i (var_mode_i),
      .cfg_win_i  (cfg_win_i),
      .cfg_ext_i  (cfg_ext_i),
      .gap_i      (gap),
      .vld_o      (calc_vld),
      .desc_o     (calc_desc)
   );

   olr_push_stage #(.DESC_W(DESC_W)) u_push (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld_i       (calc_vld),
      .desc_i      (calc_desc),
      .fifo_full_i (fifo_full_i),
      .push_o      (push_o),
      .push_desc_o (push_desc_o),
      .ovf_err_o   (ovf_err_o)
   );

   p_push_after_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> ##1 (push_o || fifo_full_i));

   p_push_needs_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> $past(trig_i, 2));
endmodule

// File: tb/sim_olap_readout_len.sv
`timescale 1ns/1ps
module sim_olap_readout_len;
   localparam int WIN_W  = 8;
   localparam int CNT_W  = 12;
   localparam int LEN_W  = WIN_W + 2;
   localparam int DESC_W = 3 + WIN_W + LEN_W;
   localparam int GAP_MAX = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_i = 1'b0, back_i = 1'b0, var_mode_i = 1'b0, fifo_full_i = 1'b0;
   logic [WIN_W-1:0] evt_win_i = '0, cfg_win_i = 8'd10, cfg_ext_i = 8'd5;
   logic push_o, ovf_err_o;
   logic [DESC_W-1:0] push_desc_o;

   always #4 clk = ~clk;

   olap_readout_len #(.WIN_W(WIN_W), .CNT_W(CNT_W), .EXT_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .back_i(back_i),
      .evt_win_i(evt_win_i), .var_mode_i(var_mode_i), .cfg_win_i(cfg_win_i),
      .cfg_ext_i(cfg_ext_i), .fifo_full_i(fifo_full_i), .push_o(push_o),
      .push_desc_o(push_desc_o), .ovf_err_o(ovf_err_o)
   );

   int checks = 0, fails = 0;
   int cyc = 0;
   int last_t = 0;
   bit seen = 1'b0;
   int prev_w = 0;
   logic [DESC_W-1:0] exp_q[$];
   logic [DESC_W-1:0] got_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   always begin
      @(negedge clk);
      #2;
      if (rst_n && push_o) got_q.push_back(push_desc_o);
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one trigger at the next negedge and record its expected descriptor.
   task automatic fire(input bit bk, input int ew, input bit dropped);
      int d, cw, rw, diff, base, ln;
      bit fr, cl;
      @(negedge clk);
      trig_i = 1'b1; back_i = bk; evt_win_i = WIN_W'(ew);
      d  = seen ? ((cyc - last_t) > GAP_MAX ? GAP_MAX : (cyc - last_t)) : GAP_MAX;
      cw = var_mode_i ? ew : int'(cfg_win_i);
      rw = var_mode_i ? prev_w : cw;
      fr = (d >= rw);
      diff = d + cw - rw;
      cl = !fr && (diff < 0);
      base = fr ? cw : (cl ? 0 : diff);
      ln = base + (bk ? int'(cfg_ext_i) : 0);
      if (!dropped) exp_q.push_back({fr, bk, cl, WIN_W'(cw), LEN_W'(ln)});
      last_t = cyc; seen = 1'b1; prev_w = cw;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         trig_i = 1'b0; back_i = 1'b0;
      end
   endtask

   task automatic compare(input string req);
      idle(6);
      chk(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size(); i++) begin
         if (i < got_q.size())
            chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
      end
      got_q.delete(); exp_q.delete();
   endtask

   task automatic t_reset;
      chk(push_o == 1'b0, "R9 push", push_o, 0);
      chk(ovf_err_o == 1'b0, "R9 ovf", ovf_err_o, 0);
   endtask

   // R1 R2 R6: first trigger, far trigger, overlapping trigger in fixed mode.
   task automatic t_fixed;
      fire(0, 0, 0);      // first after reset: saturated spacing, full window
      idle(29);
      fire(0, 0, 0);      // spacing 30 >= 10: full window
      idle(6);
      fire(0, 0, 0);      // spacing 7 < 10: length 7, not fresh
      compare("R2 fixed");
   endtask

   // R7: bursts at spacing 2 and 1.
   task automatic t_burst;
      idle(40);
      fire(0, 0, 0);
      idle(1);
      fire(0, 0, 0);
      fire(0, 0, 0);
      fire(0, 0, 0);
      idle(2);
      fire(0, 0, 0);
      compare("R7 burst");
   endtask

   // R3: go-back extension on fresh and on overlapping triggers.
   task automatic t_back;
      idle(40);
      fire(1, 0, 0);
      idle(3);
      fire(1, 0, 0);
      compare("R3 back");
   endtask

   // R4 R5: variable windows, shortening and clamping.
   task automatic t_var;
      idle(300);
      var_mode_i = 1'b1;
      fire(0, 10, 0);     // fresh, len 10
      idle(3);
      fire(0, 12, 0);     // d=4 < 10: 4+12-10 = 6
      idle(2);
      fire(0, 2, 0);      // d=3 < 12: 3+2-12 < 0: clamp, len 0
      idle(1);
      fire(1, 9, 0);      // d=2 >= 2: fresh 9 + ext 5
      idle(30);
      fire(0, 8, 0);      // fresh, len 8
      compare("R4 R5 var");
      var_mode_i = 1'b0;
   endtask

   // R1: spacing beyond the counter range must saturate, not wrap.
   task automatic t_saturate;
      idle(40);
      fire(0, 0, 0);
      idle(GAP_MAX + 5);
      fire(0, 0, 0);      // wrapped counter would read 5 < 10
      compare("R1 saturate");
   endtask

   // R8: descriptor due while full is dropped, error sticks.
   task automatic t_full;
      idle(40);
      fifo_full_i = 1'b1;
      fire(0, 0, 1);
      idle(5);
      fifo_full_i = 1'b0;
      chk(ovf_err_o == 1'b1, "R8 ovf set", ovf_err_o, 1);
      idle(3);
      fire(0, 0, 0);      // spacing measured from the dropped trigger
      compare("R8 drop");
      chk(ovf_err_o == 1'b1, "R8 ovf sticky", ovf_err_o, 1);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_burst();
      t_back();
      t_var();
      t_saturate();
      t_full();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=0", 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule